// File: doc/BRIEF.md
# Virtual Debug Panel Datapath

This block computes the values that a host-side virtual instrument panel displays for a running design. It receives the panel's sixteen virtual switches, its sixteen virtual pushbuttons and a 32-bit word typed in by the host. It also receives the scroll pattern, the button toggle state and the timeout counter value from a neighbouring LED controller. From these inputs it drives three outputs: a 24-light bar, a 32-bit word sent back to the host, and an eight-light virtual LED row.

The light bar fills one light at a time, starting at the leftmost light, on each internal tick. Two pushbuttons clear the bar or freeze it. Switches 15 and 14 pick how the returned word is formed: a free-running up counter, a free-running down counter, the inverse of the host word, or the host word mirrored end to end. Switches 9 and 8 pick the source for the two four-light halves of the LED row. The tick period is a parameter, so the block runs at any clock rate.

Top module: `vdbg_panel`

## Requirements
- R1: While `rst_n` is low and after its release, the light bar is all off and the internal counter is zero, so `word_out` reads 0 in mode 00.
- R2: On each tick the bar gains one light, filling from bit 23 (leftmost) toward bit 0; on the tick after all 24 lights are on, it returns to all off. A tick occurs on every TICK_DIV-th clock after reset release.
- R3: While `vbtn[15]` is high, the bar is all off from the next clock edge on. This takes priority over hold.
- R4: While `vbtn[14]` is high and `vbtn[15]` is low, the bar keeps its value across ticks.
- R5: With `vsw[15:14]` = 00, `word_out` shows the counter, which increments by one per tick, modulo 2^32.
- R6: With `vsw[15:14]` = 01, `word_out` shows the counter, which decrements by one per tick, modulo 2^32 (0 steps to 0xFFFFFFFF).
- R7: With `vsw[15:14]` = 10, `word_out` is the bitwise inverse of `host_word` in the same cycle, and the counter keeps its value.
- R8: With `vsw[15:14]` = 11, `word_out[i]` equals `host_word[31-i]` in the same cycle, and the counter keeps its value.
- R9: With `vsw[9]` = 0 and `vsw[8]` = 0, `vled[7:4]` shows `scroll_pat` and `vled[3:0]` shows `toggle_st`.
- R10: With `vsw[9]` = 0 and `vsw[8]` = 1, `vled[7:4]` shows `timer_val` and `vled[3:0]` shows `toggle_st`.
- R11: With `vsw[9]` = 1, whatever `vsw[8]` is, `vled[7:4]` shows `vsw[3:0]` and `vled[3:0]` shows `vbtn[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vsw | input | 16 | Virtual switch bits |
| vbtn | input | 16 | Virtual pushbutton bits |
| host_word | input | 32 | Word sent by the host |
| scroll_pat | input | 4 | Scroll pattern from the LED controller |
| toggle_st | input | 4 | Toggle state of the four physical buttons |
| timer_val | input | 4 | Timeout counter value from the LED controller |
| bar | output | 24 | Light bar, bit 23 leftmost |
| word_out | output | 32 | Word returned to the host |
| vled | output | 8 | Virtual LED row, [7:4] left half, [3:0] right half |

## Verification
The bench builds the block with TICK_DIV = 4 and keeps the default 24-light bar and 32-bit word. A four-clock tick brings a full fill-and-wrap cycle of the bar into about a hundred clocks, so every intermediate fill level can be compared against a count of edges since reset. With the same short tick, the down counter wraps from zero and the hold and clear buttons can be pressed across several ticks.

// File: rtl/vdbg_panel.sv
module vdbg_panel #(
  parameter int BAR_W    = 24,
  parameter int WORD_W   = 32,
  parameter int HALF_W   = 4,
  parameter int TICK_DIV = 1000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         vsw,
  input  logic [15:0]         vbtn,
  input  logic [WORD_W-1:0]   host_word,
  input  logic [HALF_W-1:0]   scroll_pat,
  input  logic [HALF_W-1:0]   toggle_st,
  input  logic [HALF_W-1:0]   timer_val,
  output logic [BAR_W-1:0]    bar,
  output logic [WORD_W-1:0]   word_out,
  output logic [2*HALF_W-1:0] vled
);

  localparam int TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_DIV - 1);

  logic [TICK_W-1:0] tick_cnt;
  logic              tick;
  logic [WORD_W-1:0] ctr;
  logic [WORD_W-1:0] mirrored;
  logic [1:0]        mode;

  assign mode = vsw[15:14];
  assign tick = (tick_cnt == TICK_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tick_cnt <= '0;
    else if (tick) tick_cnt <= '0;
    else           tick_cnt <= tick_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bar <= '0;
    else if (vbtn[15])         bar <= '0;
    else if (tick && !vbtn[14])
      bar <= (&bar) ? '0 : {1'b1, bar[BAR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr <= '0;
    else if (tick) begin
      case (mode)
        2'b00:   ctr <= ctr + 1'b1;
        2'b01:   ctr <= ctr - 1'b1;
        default: ctr <= ctr;
      endcase
    end
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_mirror
    assign mirrored[i] = host_word[WORD_W-1-i];
  end

  always_comb begin
    case (mode)
      2'b10:   word_out = ~host_word;
      2'b11:   word_out = mirrored;
      default: word_out = ctr;
    endcase
  end

  always_comb begin
    if (vsw[9])      vled = {vsw[HALF_W-1:0], vbtn[HALF_W-1:0]};
    else if (vsw[8]) vled = {timer_val, toggle_st};
    else             vled = {scroll_pat, toggle_st};
  end

endmodule

// File: rtl/vdbg_panel_chk.sv
module vdbg_panel_chk #(
  parameter int BAR_W  = 24,
  parameter int WORD_W = 32,
  parameter int HALF_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [15:0]         vsw,
  input logic [15:0]         vbtn,
  input logic [WORD_W-1:0]   host_word,
  input logic [BAR_W-1:0]    bar,
  input logic [WORD_W-1:0]   word_out,
  input logic [2*HALF_W-1:0] vled
);

  p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(vbtn[15]) && bar != $past(bar)) |->
      ((bar == {1'b1, $past(bar[BAR_W-1:1])}) || ($past(&bar) && bar == '0)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vbtn[15] |=> (bar == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vbtn[14] && !vbtn[15]) |=> $stable(bar));

  p_inc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vsw[15:14] == 2'b00 && $past(vsw[15:14]) == 2'b00) |->
      ((word_out - $past(word_out)) <= WORD_W'(1)));

  p_compl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vsw[15:14] == 2'b10) |-> ((word_out ^ host_word) == '1));

  p_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vsw[15:14] == 2'b11) |->
      (word_out[0] == host_word[WORD_W-1] && word_out[WORD_W-1] == host_word[0]));

  p_vled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vsw[9] |-> (vled == {vsw[HALF_W-1:0], vbtn[HALF_W-1:0]}));

endmodule

bind vdbg_panel vdbg_panel_chk #(.BAR_W(BAR_W), .WORD_W(WORD_W), .HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsw(vsw), .vbtn(vbtn), .host_word(host_word),
  .bar(bar), .word_out(word_out), .vled(vled)
);

// File: tb/vdbg_panel_test.sv
`timescale 1ns/1ps
module vdbg_panel_test;
  localparam int TD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] vsw = '0;
  logic [15:0] vbtn = '0;
  logic [31:0] host_word = '0;
  logic [3:0]  scroll_pat = 4'h0;
  logic [3:0]  toggle_st = 4'h0;
  logic [3:0]  timer_val = 4'h0;
  logic [23:0] bar;
  logic [31:0] word_out;
  logic [7:0]  vled;

  int tests = 0;
  int fails = 0;
  int n = 0;
  bit done = 0;

  vdbg_panel #(.TICK_DIV(TD)) uut (
    .clk(clk), .rst_n(rst_n), .vsw(vsw), .vbtn(vbtn), .host_word(host_word),
    .scroll_pat(scroll_pat), .toggle_st(toggle_st), .timer_val(timer_val),
    .bar(bar), .word_out(word_out), .vled(vled)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1; n++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    n = 0;
  endtask

  function automatic logic [23:0] fill(input int lights);
    if (lights == 0) return 24'h0;
    return 24'hFFFFFF << (24 - lights);
  endfunction

  task automatic t_reset();
    vsw = '0; vbtn = '0;
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 bar in reset", {8'h0, bar}, 32'h0);
    check("R1 word in reset", word_out, 32'h0);
    do_reset();
    check("R1 bar after release", {8'h0, bar}, 32'h0);
    check("R1 word after release", word_out, 32'h0);
  endtask

  task automatic t_bar_fill();
    vsw = '0; vbtn = '0;
    do_reset();
    for (int k = 0; k < 26 * TD; k++) begin
      step();
      check("R2 bar fill/wrap", {8'h0, bar}, {8'h0, fill((n / TD) % 25)});
    end
  endtask

  task automatic t_hold_clear();
    vsw = '0; vbtn = '0;
    do_reset();
    for (int k = 0; k < 2 * TD + 1; k++) step();
    check("R2 two lights", {8'h0, bar}, {8'h0, fill(2)});
    vbtn[14] = 1'b1;
    for (int k = 0; k < 3 * TD; k++) begin
      step();
      check("R4 hold keeps bar", {8'h0, bar}, {8'h0, fill(2)});
    end
    vbtn[15] = 1'b1;
    step();
    check("R3 clear over hold", {8'h0, bar}, 32'h0);
    vbtn[14] = 1'b0;
    for (int k = 0; k < 2 * TD; k++) begin
      step();
      check("R3 clear held", {8'h0, bar}, 32'h0);
    end
    vbtn[15] = 1'b0;
  endtask

  task automatic t_inc();
    vsw = '0; vbtn = '0;
    do_reset();
    for (int k = 0; k < 10 * TD; k++) begin
      step();
      check("R5 increment", word_out, 32'(n / TD));
    end
  endtask

  task automatic t_dec();
    vsw = 16'h4000; vbtn = '0;
    do_reset();
    for (int k = 0; k < 6 * TD; k++) begin
      step();
      check("R6 decrement wrap", word_out, 32'h0 - 32'(n / TD));
    end
  endtask

  task automatic t_compl();
    vsw = 16'h8000; vbtn = '0;
    do_reset();
    host_word = 32'h1000FFFF; #1;
    check("R7 inverse a", word_out, 32'hEFFF0000);
    host_word = 32'hA5A50F0F; #1;
    check("R7 inverse b", word_out, 32'h5A5AF0F0);
    for (int k = 0; k < 5 * TD; k++) step();
    vsw = 16'h0000; #1;
    check("R7 counter kept", word_out, 32'h0);
  endtask

  task automatic t_mirror();
    vsw = 16'hC000; vbtn = '0;
    do_reset();
    host_word = 32'h00000001; #1;
    check("R8 mirror lsb", word_out, 32'h80000000);
    host_word = 32'h1000FFFF; #1;
    check("R8 mirror mixed", word_out, 32'hFFFF0008);
    host_word = 32'hF0000000; #1;
    check("R8 mirror nibble", word_out, 32'h0000000F);
    for (int k = 0; k < 4 * TD; k++) step();
    vsw = 16'h0000; #1;
    check("R8 counter kept", word_out, 32'h0);
  endtask

  task automatic t_vled();
    scroll_pat = 4'h3; toggle_st = 4'hA; timer_val = 4'h6;
    vsw = 16'h0005; vbtn = 16'h0009; #1;
    check("R9 scroll/toggle", {24'h0, vled}, 32'h3A);
    vsw = 16'h0105; #1;
    check("R10 timer/toggle", {24'h0, vled}, 32'h6A);
    vsw = 16'h0205; #1;
    check("R11 switches/buttons", {24'h0, vled}, 32'h59);
    vsw = 16'h0305; #1;
    check("R11 overrides sw8", {24'h0, vled}, 32'h59);
    vsw = 16'h0000; vbtn = '0;
  endtask

  initial begin
    t_reset();
    t_bar_fill();
    t_hold_clear();
    t_inc();
    t_dec();
    t_compl();
    t_mirror();
    t_vled();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule